// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small set of one-bit ownership tokens that two independent ports, left and right, use to coordinate access to a shared resource. Each port has an active-low select strobe, a write enable, an address bus and a data bus. A port asks for a token by writing a zero into that token's slot. It hands the token back by writing a one. A read shows the caller whether it currently holds the token.

Each token keeps track of who owns it, and of a pending request from the other port. A request for a token the other port holds is not lost. It waits, and the token passes to the waiting port as soon as the owner releases it. When both ports ask for a free token in the same cycle, the bank decides between them. Every write takes effect at the next clock edge, so a port sees the result of its write on a later read.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free and nothing is pending. A read of any token by either port returns all ones.
- R2: A write by a port with its select low, write enable high and data bit 0 equal to 0 makes that port the owner of a free token from the next clock edge.
- R3: While a port's select `*_sel_ni` is high, its writes change no token state.
- R4: The token is picked by the low log2(NUM_SEM) address bits (bits 2:0 for eight tokens). Higher address bits are ignored, and other tokens are unaffected.
- R5: Only data bit 0 of a write is used. Bit 0 equal to 0 is a request and bit 0 equal to 1 is a release, whatever the other data bits hold.
- R6: A write of 1 frees a token only when the writing port owns it. Otherwise the write has no effect.
- R7: During a read (select low, write enable low), data bit 0 is 0 when the reading port owns the addressed token and 1 otherwise. All other data bits are 1. When the port is not reading, its data output is all ones.
- R8: A request for a token the other port owns is held pending. The token is granted to the requester at the edge where the owner releases it, and at no time do both ports own one token.
- R9: When both ports request the same free token in the same cycle, the left port gets it and the right request stays pending.
- R10: A request from the port that already owns the token has no effect and leaves nothing pending.
- R11: When the owner releases a token in the same cycle that the other port requests it, the requester owns the token from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_ni | input | 1 | Left semaphore select, active low |
| l_we_i | input | 1 | Left write enable (1 = write, 0 = read) |
| l_addr_i | input | ADDR_W | Left address; the low bits pick the token |
| l_data_i | input | DATA_W | Left write data; only bit 0 is used |
| l_data_o | output | DATA_W | Left read data |
| r_sel_ni | input | 1 | Right semaphore select, active low |
| r_we_i | input | 1 | Right write enable (1 = write, 0 = read) |
| r_addr_i | input | ADDR_W | Right address; the low bits pick the token |
| r_data_i | input | DATA_W | Right write data; only bit 0 is used |
| r_data_o | output | DATA_W | Right read data |

## Verification
The bench builds the bank with NUM_SEM=8, ADDR_W=12 and DATA_W=8. The twelve-bit address lets it put nonzero values in the nine unused upper bits, so it can show that these bits are ignored. The eight-bit data bus lets it show that the upper read bits stay at one and that the upper write bits have no effect. A random phase aims both ports at two tokens, which makes same-cycle collisions, pending grants and release-with-request cases frequent.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // per-token command decoded from one port access
  typedef struct packed {
    logic req;
    logic rel;
  } sem_cmd_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic              sel_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output sem_cmd_t          cmd_o [NUM_SEM]
);
  logic wr_act;
  assign wr_act = ~sel_ni & we_i;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_tok
    logic hit;
    assign hit        = wr_act && (addr_i[SEL_W-1:0] == SEL_W'(g));
    assign cmd_o[g].req = hit & ~data_i[0];
    assign cmd_o[g].rel = hit &  data_i[0];
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sem_cmd_t l_cmd_i,
  input  sem_cmd_t r_cmd_i,
  output logic     own_l_o,
  output logic     own_r_o,
  output logic     pend_l_o,
  output logic     pend_r_o
);
  logic own_l_q, own_r_q, pend_l_q, pend_r_q;
  logic own_l_d, own_r_d, pend_l_d, pend_r_d;
  logic keep_l, keep_r, want_l, want_r;

  always_comb begin
    keep_l = own_l_q & ~l_cmd_i.rel;
    keep_r = own_r_q & ~r_cmd_i.rel;
    // owner requests are dropped
    want_l = (pend_l_q | l_cmd_i.req) & ~own_l_q;
    want_r = (pend_r_q | r_cmd_i.req) & ~own_r_q;
    own_l_d  = 1'b0;
    own_r_d  = 1'b0;
    pend_l_d = 1'b0;
    pend_r_d = 1'b0;
    if (keep_l || keep_r) begin
      own_l_d  = keep_l;
      own_r_d  = keep_r;
      pend_l_d = want_l;
      pend_r_d = want_r;
    end else if (want_l) begin
      // left has fixed priority on a free token
      own_l_d  = 1'b1;
      pend_r_d = want_r;
    end else if (want_r) begin
      own_r_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_l_q  <= 1'b0;
      own_r_q  <= 1'b0;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      own_l_q  <= own_l_d;
      own_r_q  <= own_r_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o  = own_l_q;
  assign own_r_o  = own_r_q;
  assign pend_l_o = pend_l_q;
  assign pend_r_o = pend_r_q;
endmodule

// File: rtl/sem_rd_mux.sv
module sem_rd_mux #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic               sel_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SEM-1:0] own_i,
  output logic [DATA_W-1:0]  data_o
);
  always_comb begin
    data_o = '1;
    if (!sel_ni && !we_i) data_o[0] = ~own_i[addr_i[SEL_W-1:0]];
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_ni,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_data_i,
  output logic [DATA_W-1:0] l_data_o,
  input  logic              r_sel_ni,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_data_i,
  output logic [DATA_W-1:0] r_data_o
);
  sem_cmd_t           l_cmd [NUM_SEM];
  sem_cmd_t           r_cmd [NUM_SEM];
  logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_l (
    .sel_ni(l_sel_ni), .we_i(l_we_i), .addr_i(l_addr_i), .data_i(l_data_i), .cmd_o(l_cmd)
  );
  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_r (
    .sel_ni(r_sel_ni), .we_i(r_we_i), .addr_i(r_addr_i), .data_i(r_data_i), .cmd_o(r_cmd)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell i_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .l_cmd_i (l_cmd[g]),
      .r_cmd_i (r_cmd[g]),
      .own_l_o (own_l[g]),
      .own_r_o (own_r[g]),
      .pend_l_o(pend_l[g]),
      .pend_r_o(pend_r[g])
    );
  end

  sem_rd_mux #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd_l (
    .sel_ni(l_sel_ni), .we_i(l_we_i), .addr_i(l_addr_i), .own_i(own_l), .data_o(l_data_o)
  );
  sem_rd_mux #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd_r (
    .sel_ni(r_sel_ni), .we_i(r_we_i), .addr_i(r_addr_i), .own_i(own_r), .data_o(r_data_o)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_sel_ni,
  input logic               l_we_i,
  input logic [ADDR_W-1:0]  l_addr_i,
  input logic [DATA_W-1:0]  l_data_i,
  input logic [DATA_W-1:0]  l_data_o,
  input logic               r_sel_ni,
  input logic               r_we_i,
  input logic [ADDR_W-1:0]  r_addr_i,
  input logic [DATA_W-1:0]  r_data_i,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r,
  input logic [NUM_SEM-1:0] pend_l,
  input logic [NUM_SEM-1:0] pend_r
);
  logic [SEL_W-1:0] l_idx, r_idx;
  logic             l_wr0, r_wr0;
  assign l_idx = l_addr_i[SEL_W-1:0];
  assign r_idx = r_addr_i[SEL_W-1:0];
  assign l_wr0 = !l_sel_ni && l_we_i && !l_data_i[0];
  assign r_wr0 = !r_sel_ni && r_we_i && !r_data_i[0];

  assert_left_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr0 && r_wr0 && l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx])
    |=> (own_l[$past(l_idx)] && pend_r[$past(l_idx)]));

  assert_grant_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr0 && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

  assert_single_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  assert_idle_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_sel_ni && r_sel_ni)
    |=> ($stable(own_l) && $stable(own_r) && $stable(pend_l) && $stable(pend_r)));

  assert_owner_not_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((own_l & pend_l) == '0) && ((own_r & pend_r) == '0));

  assert_read_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sel_ni && !l_we_i) |-> (l_data_o[0] == !own_l[l_idx] && (&l_data_o[DATA_W-1:1])));
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .l_sel_ni(l_sel_ni),
  .l_we_i  (l_we_i),
  .l_addr_i(l_addr_i),
  .l_data_i(l_data_i),
  .l_data_o(l_data_o),
  .r_sel_ni(r_sel_ni),
  .r_we_i  (r_we_i),
  .r_addr_i(r_addr_i),
  .r_data_i(r_data_i),
  .own_l   (own_l),
  .own_r   (own_r),
  .pend_l  (pend_l),
  .pend_r  (pend_r)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int SW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          l_sel_ni = 1'b1, l_we_i = 1'b0;
  logic [AW-1:0] l_addr_i = '0;
  logic [DW-1:0] l_data_i = '0;
  logic [DW-1:0] l_data_o;
  logic          r_sel_ni = 1'b1, r_we_i = 1'b0;
  logic [AW-1:0] r_addr_i = '0;
  logic [DW-1:0] r_data_i = '0;
  logic [DW-1:0] r_data_o;

  always #10 clk_i = ~clk_i;

  sem_bank #(.NUM_SEM(N), .ADDR_W(AW), .DATA_W(DW)) i_sem_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_sel_ni(l_sel_ni), .l_we_i(l_we_i), .l_addr_i(l_addr_i), .l_data_i(l_data_i), .l_data_o(l_data_o),
    .r_sel_ni(r_sel_ni), .r_we_i(r_we_i), .r_addr_i(r_addr_i), .r_data_i(r_data_i), .r_data_o(r_data_o)
  );

  // reference model: 0 free, 1 left, 2 right
  int owner [N];
  bit wait_l [N];
  bit wait_r [N];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic void model_reset();
    for (int t = 0; t < N; t++) begin
      owner[t] = 0; wait_l[t] = 0; wait_r[t] = 0;
    end
  endfunction

  function automatic void model_step(logic ls, logic lw, logic [AW-1:0] la, logic [DW-1:0] ld,
                                     logic rs, logic rw, logic [AW-1:0] ra, logic [DW-1:0] rd);
    int tl = int'(la[SW-1:0]);
    int tr = int'(ra[SW-1:0]);
    bit lwr = !ls && lw;
    bit rwr = !rs && rw;
    if (lwr && ld[0] && owner[tl] == 1) owner[tl] = 0;
    if (rwr && rd[0] && owner[tr] == 2) owner[tr] = 0;
    if (lwr && !ld[0] && owner[tl] != 1) wait_l[tl] = 1;
    if (rwr && !rd[0] && owner[tr] != 2) wait_r[tr] = 1;
    for (int t = 0; t < N; t++) begin
      if (owner[t] == 0) begin
        if (wait_l[t]) begin owner[t] = 1; wait_l[t] = 0; end
        else if (wait_r[t]) begin owner[t] = 2; wait_r[t] = 0; end
      end
    end
  endfunction

  task automatic check_port(string tag, string side, logic [DW-1:0] act,
                            logic s, logic w, logic [AW-1:0] a, int who);
    logic [DW-1:0] exp;
    exp = '1;
    if (!s && !w) exp[0] = (owner[int'(a[SW-1:0])] != who);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s port addr=%0d actual=%h expected=%h", tag, side, a, act, exp);
    end
  endtask

  task automatic tick(string tag,
                      logic ls, logic lw, logic [AW-1:0] la, logic [DW-1:0] ld,
                      logic rs, logic rw, logic [AW-1:0] ra, logic [DW-1:0] rd);
    @(negedge clk_i);
    l_sel_ni = ls; l_we_i = lw; l_addr_i = la; l_data_i = ld;
    r_sel_ni = rs; r_we_i = rw; r_addr_i = ra; r_data_i = rd;
    #5;
    check_port(tag, "left", l_data_o, ls, lw, la, 1);
    check_port(tag, "right", r_data_o, rs, rw, ra, 2);
    @(posedge clk_i);
    model_step(ls, lw, la, ld, rs, rw, ra, rd);
  endtask

  task automatic scan(string tag);
    for (int t = 0; t < N; t++)
      tick(tag, 1'b0, 1'b0, AW'(t) | 12'hA50, '0, 1'b0, 1'b0, AW'(t), '0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 / R7: all free after reset
    scan("R1 reset");
    // R2 / R4: left requests token 3 with junk upper address bits
    tick("R2 req", 1'b0, 1'b1, 12'hA53, 8'h00, 1'b1, 1'b0, 12'h000, 8'h00);
    tick("R4 read", 1'b0, 1'b0, 12'h003, 8'h00, 1'b0, 1'b0, 12'hFF3, 8'h00);
    scan("R4 others");
    // R3: deselected write ignored
    tick("R3 desel", 1'b1, 1'b1, 12'h005, 8'h00, 1'b1, 1'b1, 12'h005, 8'h00);
    tick("R3 read", 1'b0, 1'b0, 12'h005, 8'h00, 1'b0, 1'b0, 12'h005, 8'h00);
    // R5: upper data bits ignored (FE is request, 01 release)
    tick("R5 req", 1'b0, 1'b1, 12'hF2C, 8'hFE, 1'b1, 1'b0, 12'h000, 8'h00);
    tick("R5 read", 1'b0, 1'b0, 12'h004, 8'h00, 1'b0, 1'b0, 12'h004, 8'h00);
    // R6: right release of left-owned token 3 has no effect
    tick("R6 foreign", 1'b1, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 12'h003, 8'hFF);
    tick("R6 read", 1'b0, 1'b0, 12'h003, 8'h00, 1'b0, 1'b0, 12'h003, 8'h00);
    tick("R6 rel", 1'b0, 1'b1, 12'h003, 8'h01, 1'b1, 1'b0, 12'h000, 8'h00);
    tick("R6 read", 1'b0, 1'b0, 12'h003, 8'h00, 1'b0, 1'b0, 12'h003, 8'h00);
    // R8: right waits on token 4, gets it when left releases
    tick("R8 pend", 1'b1, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 12'h004, 8'h00);
    tick("R8 wait", 1'b0, 1'b0, 12'h004, 8'h00, 1'b0, 1'b0, 12'h004, 8'h00);
    tick("R8 rel", 1'b0, 1'b1, 12'h004, 8'h81, 1'b1, 1'b0, 12'h000, 8'h00);
    tick("R8 grant", 1'b0, 1'b0, 12'h004, 8'h00, 1'b0, 1'b0, 12'h004, 8'h00);
    // R9: same-cycle request on token 6
    tick("R9 both", 1'b0, 1'b1, 12'h006, 8'h00, 1'b0, 1'b1, 12'h006, 8'h00);
    tick("R9 read", 1'b0, 1'b0, 12'h006, 8'h00, 1'b0, 1'b0, 12'h006, 8'h00);
    tick("R9 rel", 1'b0, 1'b1, 12'h006, 8'h01, 1'b1, 1'b0, 12'h000, 8'h00);
    tick("R9 grant", 1'b0, 1'b0, 12'h006, 8'h00, 1'b0, 1'b0, 12'h006, 8'h00);
    // R10: owner re-request leaves nothing pending
    tick("R10 rereq", 1'b1, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 12'h006, 8'h00);
    tick("R10 rel", 1'b1, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 12'h006, 8'h01);
    tick("R10 free", 1'b0, 1'b0, 12'h006, 8'h00, 1'b0, 1'b0, 12'h006, 8'h00);
    // R11: left releases token 2 while right requests it
    tick("R11 setup", 1'b0, 1'b1, 12'h002, 8'h00, 1'b1, 1'b0, 12'h000, 8'h00);
    tick("R11 swap", 1'b0, 1'b1, 12'h002, 8'h01, 1'b0, 1'b1, 12'h002, 8'h00);
    tick("R11 read", 1'b0, 1'b0, 12'h002, 8'h00, 1'b0, 1'b0, 12'h002, 8'h00);
    scan("R7 scan");
    // mixed random traffic on two tokens
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] la, ra;
      la = AW'($urandom) & ~AW'(N - 1) | AW'($urandom_range(0, 1));
      ra = AW'($urandom) & ~AW'(N - 1) | AW'($urandom_range(0, 1));
      tick("R8 random",
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1), la, DW'($urandom),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1), ra, DW'($urandom));
    end
    scan("R11 final");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule